// File: doc/BRIEF.md
# Receive FIFO threshold controller

This block is the receive half of a two-wire serial bus controller working in buffered mode. A bit-level bus engine delivers bytes one at a time. The block stores them in a 16-entry ring and asks for more only until a software-programmed threshold count is buffered. It then stops requesting bytes and raises a threshold flag. If software armed the one-shot final-byte flag, the block also tells the engine to answer the last byte with a NACK.

Software sets up the receive through a small control/status register pair. It drains the ring one byte per data-read strobe. A data read on an empty ring does not return a byte. Instead it starts the next fill. Writing one to the threshold flag clears the flag, and it also restarts filling while a receive is in progress. A threshold set above the ring size cannot be met. In that case filling stops at 16 bytes, the flag is never set, and a sticky error output reports the condition.

Top module: `rxf_threshold_ctrl`

## Requirements
- R1: After reset, the control register reads 0x01 (threshold 1, final-byte flag 0, interrupt enable 0), the status register reads 0x00, and fill_req, data_ready, fifo_ready, thr_irq, nack_req and thr_err are all low.
- R2: Any of three triggers can start a fill:
  - a fill_start pulse;
  - a data read when the ring is empty;
  - a write of 1 to status bit 6 while rx_active is high.
  A trigger starts a fill only when the buffered count is below both the threshold and 16. Once started, fill_req stays high until the count reaches the threshold or 16. An rx_valid seen while fill_req is low is ignored.
- R3: Bytes leave the ring in arrival order. Each new byte is written at slot (read pointer + count) mod 16. Status bits 4:0 give the buffered count.
- R4: When an accepted byte brings the count up to the threshold (control bits 4:0), status bit 6 is set. thr_irq is high exactly when status bit 6 and control bit 6 (interrupt enable) are both set.
- R5: Control bit 5 is the final-byte flag. Writing 1 sets it, and writing 0 leaves it unchanged. If it is set when the threshold is reached, nack_req pulses high for one cycle in the following cycle, and the flag clears.
- R6: When the threshold is reached, the outcome depends on the count:
  - if the count is 16, data_ready and fifo_ready are both set;
  - otherwise fifo_ready is unchanged and data_ready takes the inverse of the interrupt enable.
- R7: Writing 1 to status bit 6 clears the threshold flag. Writing 1 to status bit 7 (which reads back as fifo_ready) clears fifo_ready. Writing 0 to either bit has no effect.
- R8: A data read with a non-empty ring places the oldest byte on data_out from the next cycle and decrements the count. A data read with an empty ring leaves data_out unchanged.
- R9: With a threshold above 16, filling stops at 16 bytes and status bit 6 stays clear. thr_err is then set and stays set until reset.
- R10: A trigger is ignored, and no fill starts, when the count already equals the threshold, including a threshold of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_start | input | 1 | Bus engine pulse: a read transfer has begun, start filling |
| rx_active | input | 1 | A receive transfer is in progress |
| rx_valid | input | 1 | Received byte valid this cycle |
| rx_data | input | 8 | Received byte |
| fill_req | output | 1 | Block wants more bytes from the bus |
| nack_req | output | 1 | One-cycle request to NACK the final byte |
| reg_sel | input | 1 | 0 selects the control register, 1 the status register |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Selected register contents |
| data_rd | input | 1 | Data-read strobe |
| data_out | output | 8 | Most recently popped byte |
| data_ready | output | 1 | Data-ready flag |
| fifo_ready | output | 1 | Ring filled to 16 at threshold |
| thr_irq | output | 1 | Threshold interrupt |
| thr_err | output | 1 | Sticky: threshold above ring size was hit |

## Verification
The bench targets the points where a byte can be lost or one too many can be taken:
- It checks that filling stops on the exact threshold byte. A design that compared after the write would take one extra byte and shift the ring contents.
- It drains the ring across many rounds so the read pointer wraps. A slot computed without the modulo would then return stale data.
- It writes 0 to the final-byte flag and expects the flag to survive. A plain register would drop the NACK.
- It restarts fills through a status write both with and without rx_active, and sets thresholds of 0, 16 and 20. These catch a fill that starts when it should not, a missing full/ready pair, and an error flag that is not sticky.

// File: rtl/rxf_pkg.sv
`timescale 1ns/1ps
package rxf_pkg;
  localparam int THR_W     = 5;
  localparam int CTL_LAST  = 5;
  localparam int CTL_TIE   = 6;
  localparam int STS_THST  = 6;
  localparam int STS_FRDY  = 7;

  // slot that is 'offset' places past 'base' in a ring of 'depth'
  function automatic int ring_slot(int base, int offset, int depth);
    return (base + offset) % depth;
  endfunction

  // a fill may begin only below both the threshold and the ring size
  function automatic bit fill_may_start(int count, int thr, int depth);
    return (count < thr) && (count < depth);
  endfunction

  // one more byte lands the count exactly on 'target'
  function automatic bit lands_on(int count, int target);
    return (count + 1) == target;
  endfunction
endpackage

// File: rtl/rxf_ring.sv
`timescale 1ns/1ps
module rxf_ring #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [DW-1:0]    push_data,
  input  logic             pop,
  output logic [CNT_W-1:0] count,
  output logic [DW-1:0]    head
);
  import rxf_pkg::*;

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] rptr;
  logic [PTR_W-1:0] wr_idx;
  logic [PTR_W-1:0] rptr_next;

  assign wr_idx    = PTR_W'(ring_slot(int'(rptr), int'(count), DEPTH));
  assign rptr_next = PTR_W'(ring_slot(int'(rptr), 1, DEPTH));
  assign head      = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_idx] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr  <= '0;
      count <= '0;
    end else begin
      if (pop) rptr <= rptr_next;
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (int'(count) < DEPTH));
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));
  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (count == $past(count) + CNT_W'(1)));
endmodule

// File: rtl/rxf_fill.sv
`timescale 1ns/1ps
module rxf_fill #(
  parameter int DEPTH = 16,
  parameter int THR_W = 5,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trigger,
  input  logic             push,
  input  logic [CNT_W-1:0] count,
  input  logic [THR_W-1:0] thr,
  output logic             filling,
  output logic             ev_start,
  output logic             ev_hit,
  output logic             ev_full,
  output logic             ev_clamp
);
  import rxf_pkg::*;

  assign ev_start = trigger && !filling &&
                    fill_may_start(int'(count), int'(thr), DEPTH);
  assign ev_hit   = push && lands_on(int'(count), int'(thr));
  assign ev_full  = push && lands_on(int'(count), DEPTH);
  assign ev_clamp = ev_full && (int'(thr) > DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               filling <= 1'b0;
    else if (ev_start)        filling <= 1'b1;
    else if (ev_hit || ev_full) filling <= 1'b0;
  end

  assert_fill_below_depth_R2: assert property (@(posedge clk) disable iff (!rst_n)
    filling |-> (int'(count) < DEPTH));
  assert_stop_at_threshold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hit || ev_full) |=> !filling);
  assert_no_start_at_threshold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!filling && (int'(count) == int'(thr))) |=> !filling);
endmodule

// File: rtl/rxf_regs.sv
`timescale 1ns/1ps
module rxf_regs #(
  parameter int DEPTH = 16,
  parameter int THR_W = 5,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic             stat_wr,
  input  logic [7:0]       wdata,
  input  logic             sel_status,
  input  logic             ev_hit,
  input  logic             ev_full,
  input  logic             ev_clamp,
  input  logic [CNT_W-1:0] count,
  output logic [7:0]       rdata,
  output logic [THR_W-1:0] thr,
  output logic             data_ready,
  output logic             fifo_ready,
  output logic             thr_irq,
  output logic             nack_req,
  output logic             thr_err
);
  import rxf_pkg::*;

  logic ie_q, last_q, thst_q;
  logic [7:0] ctrl_view, stat_view;

  assign ctrl_view = {1'b0, ie_q, last_q, thr};
  assign stat_view = {fifo_ready, thst_q, 1'b0, THR_W'(count)};
  assign rdata     = sel_status ? stat_view : ctrl_view;
  assign thr_irq   = ie_q && thst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr        <= THR_W'(1);
      ie_q       <= 1'b0;
      last_q     <= 1'b0;
      thst_q     <= 1'b0;
      fifo_ready <= 1'b0;
      data_ready <= 1'b0;
      nack_req   <= 1'b0;
      thr_err    <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        thr  <= wdata[THR_W-1:0];
        ie_q <= wdata[CTL_TIE];
      end
      if (ctrl_wr && wdata[CTL_LAST]) last_q <= 1'b1;
      else if (ev_hit)                last_q <= 1'b0;
      nack_req <= ev_hit && last_q;

      if (ev_hit)                          thst_q <= 1'b1;
      else if (stat_wr && wdata[STS_THST]) thst_q <= 1'b0;

      if (ev_hit && ev_full)               fifo_ready <= 1'b1;
      else if (stat_wr && wdata[STS_FRDY]) fifo_ready <= 1'b0;

      if (ev_hit) data_ready <= ev_full ? 1'b1 : !ie_q;
      if (ev_clamp) thr_err <= 1'b1;
    end
  end

  assert_hit_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> thst_q);
  assert_nack_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    nack_req |=> !nack_req);
  assert_full_implies_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_ready) |-> data_ready);
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    thr_err |=> thr_err);
  assert_clamp_no_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clamp |-> !ev_hit);
endmodule

// File: rtl/rxf_threshold_ctrl.sv
`timescale 1ns/1ps
module rxf_threshold_ctrl #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fill_start,
  input  logic          rx_active,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          fill_req,
  output logic          nack_req,
  input  logic          reg_sel,
  input  logic          reg_wr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          data_rd,
  output logic [DW-1:0] data_out,
  output logic          data_ready,
  output logic          fifo_ready,
  output logic          thr_irq,
  output logic          thr_err
);
  import rxf_pkg::*;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] count;
  logic [DW-1:0]    head;
  logic [THR_W-1:0] thr;
  logic push, pop, trigger, ring_empty;
  logic ctrl_wr, stat_wr;
  logic ev_start, ev_hit, ev_full, ev_clamp;

  assign ring_empty = (count == '0);
  assign push       = rx_valid && fill_req;
  assign pop        = data_rd && !ring_empty;
  assign ctrl_wr    = reg_wr && !reg_sel;
  assign stat_wr    = reg_wr && reg_sel;
  assign trigger    = fill_start || (data_rd && ring_empty) ||
                      (stat_wr && reg_wdata[STS_THST] && rx_active);

  rxf_ring #(.DEPTH(DEPTH), .DW(DW)) u_ring (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(rx_data),
    .pop(pop), .count(count), .head(head)
  );

  rxf_fill #(.DEPTH(DEPTH), .THR_W(THR_W)) u_fill (
    .clk(clk), .rst_n(rst_n), .trigger(trigger), .push(push),
    .count(count), .thr(thr), .filling(fill_req), .ev_start(ev_start),
    .ev_hit(ev_hit), .ev_full(ev_full), .ev_clamp(ev_clamp)
  );

  rxf_regs #(.DEPTH(DEPTH), .THR_W(THR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .stat_wr(stat_wr),
    .wdata(reg_wdata), .sel_status(reg_sel), .ev_hit(ev_hit),
    .ev_full(ev_full), .ev_clamp(ev_clamp), .count(count),
    .rdata(reg_rdata), .thr(thr), .data_ready(data_ready),
    .fifo_ready(fifo_ready), .thr_irq(thr_irq), .nack_req(nack_req),
    .thr_err(thr_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   data_out <= '0;
    else if (pop) data_out <= head;
  end

  assert_start_raises_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> fill_req);
  assert_empty_read_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && ring_empty) |=> $stable(data_out));
endmodule

// File: tb/test_rxf_threshold_ctrl.sv
`timescale 1ns/1ps
module test_rxf_threshold_ctrl;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic fill_start = 0, rx_active = 0, rx_valid = 0;
  logic [7:0] rx_data = 0;
  logic fill_req, nack_req;
  logic reg_sel = 0, reg_wr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic data_rd = 0;
  logic [7:0] data_out;
  logic data_ready, fifo_ready, thr_irq, thr_err;
  logic stray = 0;

  rxf_threshold_ctrl i_rxf_threshold_ctrl (
    .clk(clk), .rst_n(rst_n), .fill_start(fill_start), .rx_active(rx_active),
    .rx_valid(rx_valid), .rx_data(rx_data), .fill_req(fill_req),
    .nack_req(nack_req), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .data_rd(data_rd),
    .data_out(data_out), .data_ready(data_ready), .fifo_ready(fifo_ready),
    .thr_irq(thr_irq), .thr_err(thr_err)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // behavioural reference
  logic [7:0] q[$];
  int m_thr = 1;
  bit m_ie = 0, m_last = 0, m_thst = 0, m_frdy = 0, m_dr = 0;
  bit m_err = 0, m_nack = 0, m_fill = 0;
  logic [7:0] m_dout = 0;
  int oc, othr;
  bit mpush, mhit, mfull, mtrig;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_thr = 1; m_ie = 0; m_last = 0; m_thst = 0; m_frdy = 0; m_dr = 0;
      m_err = 0; m_nack = 0; m_fill = 0; m_dout = 0;
    end else begin
      oc = q.size(); othr = m_thr;
      mpush = rx_valid && m_fill;
      mhit  = mpush && (oc + 1 == othr);
      mfull = mpush && (oc + 1 == 16);
      mtrig = fill_start || (data_rd && oc == 0) ||
              (reg_wr && reg_sel && reg_wdata[6] && rx_active);
      if (data_rd && oc > 0) m_dout = q.pop_front();
      if (mpush) q.push_back(rx_data);
      m_nack = mhit && m_last;
      if (reg_wr && !reg_sel && reg_wdata[5]) m_last = 1;
      else if (mhit) m_last = 0;
      if (mhit) m_thst = 1;
      else if (reg_wr && reg_sel && reg_wdata[6]) m_thst = 0;
      if (mhit && mfull) m_frdy = 1;
      else if (reg_wr && reg_sel && reg_wdata[7]) m_frdy = 0;
      if (mhit) m_dr = mfull ? 1'b1 : !m_ie;
      if (mfull && othr > 16) m_err = 1;
      if (!m_fill && mtrig && oc < othr && oc < 16) m_fill = 1;
      else if (mhit || mfull) m_fill = 0;
      if (reg_wr && !reg_sel) begin
        m_thr = int'(reg_wdata[4:0]);
        m_ie  = reg_wdata[6];
      end
    end
  end

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      chk("R2", "fill_req", {7'd0, fill_req}, {7'd0, m_fill});
      chk("R6", "data_ready", {7'd0, data_ready}, {7'd0, m_dr});
      chk("R6", "fifo_ready", {7'd0, fifo_ready}, {7'd0, m_frdy});
      chk("R4", "thr_irq", {7'd0, thr_irq}, {7'd0, m_ie && m_thst});
      chk("R5", "nack_req", {7'd0, nack_req}, {7'd0, m_nack});
      chk("R9", "thr_err", {7'd0, thr_err}, {7'd0, m_err});
      chk("R8", "data_out", data_out, m_dout);
      if (reg_sel)
        chk("R3", "status", reg_rdata,
            {m_frdy, m_thst, 1'b0, 5'(q.size())});
      else
        chk("R5", "control", reg_rdata, {1'b0, m_ie, m_last, 5'(m_thr)});
    end
  end

  // bus engine: supplies bytes with gaps while asked
  logic [7:0] bcnt = 8'h30;
  always @(posedge clk) begin
    #1;
    rx_valid = (fill_req && (bcnt % 3 != 2)) || stray;
    rx_data  = bcnt;
    bcnt     = bcnt + 8'd1;
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic peek(input logic sel, output logic [7:0] v);
    reg_sel = sel; #0.5; v = reg_rdata;
  endtask

  task automatic wr(input logic sel, input logic [7:0] v);
    reg_sel = sel; reg_wr = 1; reg_wdata = v; tick(); reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic start_fill();
    fill_start = 1; tick(); fill_start = 0;
  endtask

  task automatic rd(int n);
    for (int i = 0; i < n; i++) begin data_rd = 1; tick(); data_rd = 0; tick(); end
  endtask

  task automatic wait_done();
    for (int i = 0; i < 200 && fill_req; i++) tick();
    tick();
  endtask

  task automatic summary();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) tick();
    rst_n = 1; tick();
    // R1 reset state
    peek(0, v); chk("R1", "reset control", v, 8'h01);
    peek(1, v); chk("R1", "reset status", v, 8'h00);
    chk("R1", "reset outputs",
        {2'b0, fill_req, nack_req, data_ready, fifo_ready, thr_irq, thr_err}, 8'h00);
    reg_sel = 1;

    // R3/R4 basic threshold of 4
    wr(0, 8'h04); start_fill(); wait_done();
    peek(1, v); chk("R4", "flag at threshold", v & 8'h5f, 8'h44);
    rd(2);

    // R5 final-byte flag: set, write 0 keeps, NACK at threshold
    wr(0, 8'h24); wr(0, 8'h04);
    peek(0, v); chk("R5", "last kept on write 0", v & 8'h20, 8'h20);
    rx_active = 1; wr(1, 8'h40); rx_active = 0; wait_done();
    peek(0, v); chk("R5", "last self-clears", v & 8'h20, 8'h00);
    rd(4);

    // R8 empty read triggers a fill
    peek(1, v); chk("R8", "ring empty", v & 8'h1f, 8'h00);
    rd(1); wait_done(); rd(4);

    // R7 clear without rx_active: no refill; R4/R6 with enable
    wr(0, 8'h43); wr(1, 8'h40);
    chk("R7", "no refill without rx_active", {7'd0, fill_req}, 8'h00);
    peek(1, v); chk("R7", "flag cleared", v & 8'h40, 8'h00);
    start_fill(); wait_done();
    chk("R6", "data_ready off with enable", {7'd0, data_ready}, 8'h00);
    chk("R4", "irq raised", {7'd0, thr_irq}, 8'h01);
    rd(3);

    // R6 threshold 16 fills the ring
    wr(0, 8'h10); wr(1, 8'h40); start_fill(); wait_done();
    chk("R6", "fifo_ready at 16", {7'd0, fifo_ready}, 8'h01);
    wr(1, 8'h80);
    chk("R7", "fifo_ready cleared", {7'd0, fifo_ready}, 8'h00);
    rd(16);

    // R9 threshold above 16
    wr(0, 8'h14); wr(1, 8'h40); start_fill(); wait_done();
    peek(1, v); chk("R9", "stops at 16 no flag", v, 8'h10);
    rd(16);
    wr(0, 8'h02);
    chk("R9", "error sticky", {7'd0, thr_err}, 8'h01);

    // R10 threshold 0 and count equal to threshold
    wr(0, 8'h00); start_fill();
    chk("R10", "no fill at threshold 0", {7'd0, fill_req}, 8'h00);
    wr(0, 8'h02); start_fill(); wait_done(); start_fill();
    chk("R10", "no fill when count equals threshold", {7'd0, fill_req}, 8'h00);
    rd(2);

    // R2 stray bytes ignored
    stray = 1; repeat (5) tick(); stray = 0; tick();
    peek(1, v); chk("R2", "stray bytes ignored", v & 8'h1f, 8'h00);

    // R3 pointer wrap across many rounds
    for (int r = 0; r < 24; r++) begin
      wr(0, 8'((r % 7) + 1) | (r % 2 == 1 ? 8'h40 : 8'h00));
      wr(1, 8'h40);
      start_fill(); wait_done();
      rd((r % 7) + 1);
    end

    repeat (4) tick();
    summary();
    $finish;
  end
endmodule